// File: doc/BRIEF.md
# Segmented Packet Stream Monitor

This block watches the receive side of a wide streaming bus that carries transaction-layer packets. The bus is cut into equal segments (four of 256 bits by default, 1024 bits in all), and every segment carries its own flag for a header starting there and its own flag for a packet finishing there. Several packets may therefore begin and end inside one beat. The monitor never touches payload or header contents. On each accepted beat it walks the segments from the lowest upward, keeps track of whether a packet is open, counts packets that begin and packets that complete, and records any framing or byte-enable rule that the beat breaks.

Violations are collected in a sticky error vector with one bit per rule. The vector clears only on synchronous reset, so software or a higher-level checker may sample it at any time. The monitor also drives the bus ready signal from an enable input. A ready-latency parameter chooses whether a beat is taken in the same cycle as ready, or a fixed number of cycles after ready was raised.

Top module: `seg_pkt_monitor`

## Requirements
- R1: A beat is accepted only on a cycle where `in_valid` is high and the acceptance condition of R2 holds; on every other cycle the segment flags, byte enables and last flag change no output.
- R2: `out_ready` equals `rdy_en` in the same cycle. With READY_LAT = 0 a beat is accepted when `in_valid` and `rdy_en` are high together; with READY_LAT = L > 0 a beat is accepted when `in_valid` is high and `rdy_en` was high L cycles earlier.
- R3: One cycle after an accepted beat, `beat_starts` holds the number of set bits of `in_seg_hdr` on that beat; one cycle after a cycle with no accepted beat it reads 0.
- R4: Segments are scanned from bit 0 upward, a header flag before the end flag within one segment; every end flag that closes an open packet adds one to `pkt_done_cnt`, visible one cycle after the beat. An open packet stays open across beats.
- R5: `err_flags[0]` is set when an accepted beat has `in_last` low and any bit of `in_keep` clear.
- R6: `err_flags[1]` is set when an accepted beat has sparse byte enables: the set bits of `in_keep` are not one contiguous run starting at bit 0 (all-zero counts as contiguous).
- R7: `err_flags[2]` is set when an accepted beat carries more than MAX_STARTS (default 3) header flags.
- R8: `err_flags[3]` is set when a header flag is seen while a packet is already open; the new packet then becomes the open one.
- R9: `err_flags[4]` is set when an end flag is seen while no packet is open; the flag is otherwise ignored.
- R10: `err_flags[5]` is set when `in_last` on an accepted beat differs from "no packet open after the highest segment".
- R11: After synchronous reset all outputs read 0 and no packet is open; once set, an error bit stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy_en | input | 1 | Enable that drives the ready output |
| out_ready | output | 1 | Ready towards the stream source |
| in_valid | input | 1 | Source drives a beat |
| in_keep | input | SEG_COUNT*SEG_BITS/8 | Byte enables, bit 0 is the lowest byte |
| in_last | input | 1 | Final beat of a transfer |
| in_seg_end | input | SEG_COUNT | Per-segment packet-end flags |
| in_seg_hdr | input | SEG_COUNT | Per-segment header-start flags |
| pkt_done_cnt | output | CNT_W | Running count of completed packets (wraps) |
| beat_starts | output | $clog2(SEG_COUNT+1) | Header count of the last cycle's accepted beat |
| err_flags | output | 6 | Sticky rule-violation bits, see R5 to R10 |

## Verification
The bound checker watches, on every cycle, that the per-beat start count follows the header flags of the accepted beat and drops to zero when nothing is taken, that the completed-packet count holds still without a transfer and never steps by more than the segment count, that byte-enable holes and start-limit breaches set their bits, and that error bits never fall. The segment-order scan itself (which end closes which packet, when a missing or orphan end is declared, and whether the last flag matches the open state) and the delayed acceptance under a nonzero ready latency depend on history across segments and beats, so only the bench's directed and random sequences, compared against its own reference model, show them.

// File: rtl/seg_pkt_pkg.sv
package seg_pkt_pkg;
   localparam int ERR_W = 6;

   localparam int E_KEEP_HOLE     = 0;
   localparam int E_KEEP_SPARSE   = 1;
   localparam int E_START_LIMIT   = 2;
   localparam int E_MISSING_END   = 3;
   localparam int E_ORPHAN_END    = 4;
   localparam int E_LAST_MISMATCH = 5;

   typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/spm_keep_check.sv
// Byte-enable rules for one beat: holes only on the last beat, never sparse.
module spm_keep_check #(
   parameter int KEEP_W = 128
) (
   input  logic [KEEP_W-1:0] keep,
   input  logic              last,
   output logic              hole_err,
   output logic              sparse_err
);
   logic [KEEP_W-1:0] keep_inc;

   always_comb begin
      keep_inc   = keep + KEEP_W'(1);
      // A contiguous run from bit 0 turns into a single carry bit (or zero).
      sparse_err = |(keep & keep_inc);
      hole_err   = !last && !(&keep);
   end
endmodule

// File: rtl/spm_seg_scan.sv
// Walks the segments of one beat from the lowest upward.
module spm_seg_scan #(
   parameter int SEG_COUNT = 4,
   localparam int SC_W = $clog2(SEG_COUNT + 1)
) (
   input  logic                 open_in,
   input  logic [SEG_COUNT-1:0] seg_hdr,
   input  logic [SEG_COUNT-1:0] seg_end,
   output logic                 open_out,
   output logic [SC_W-1:0]      n_starts,
   output logic [SC_W-1:0]      n_done,
   output logic                 missing_err,
   output logic                 orphan_err
);
   always_comb begin
      logic open_v;
      open_v      = open_in;
      n_starts    = '0;
      n_done      = '0;
      missing_err = 1'b0;
      orphan_err  = 1'b0;
      for (int i = 0; i < SEG_COUNT; i++) begin
         if (seg_hdr[i]) begin
            n_starts = n_starts + SC_W'(1);
            if (open_v) missing_err = 1'b1;
            open_v = 1'b1;
         end
         if (seg_end[i]) begin
            if (open_v) begin
               n_done = n_done + SC_W'(1);
               open_v = 1'b0;
            end else begin
               orphan_err = 1'b1;
            end
         end
      end
      open_out = open_v;
   end
endmodule

// File: rtl/spm_tally.sv
// State and output registers: open flag, counters, sticky error vector.
module spm_tally
   import seg_pkt_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int SC_W  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             xfer,
   input  logic             open_next,
   input  logic [SC_W-1:0]  n_starts,
   input  logic [SC_W-1:0]  n_done,
   input  err_vec_t         new_err,
   output logic             pkt_open,
   output logic [CNT_W-1:0] pkt_done_cnt,
   output logic [SC_W-1:0]  beat_starts,
   output err_vec_t         err_flags
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pkt_open     <= 1'b0;
         pkt_done_cnt <= '0;
         beat_starts  <= '0;
         err_flags    <= '0;
      end else if (xfer) begin
         pkt_open     <= open_next;
         pkt_done_cnt <= pkt_done_cnt + CNT_W'(n_done);
         beat_starts  <= n_starts;
         err_flags    <= err_flags | new_err;
      end else begin
         beat_starts  <= '0;
      end
   end
endmodule

// File: rtl/seg_pkt_monitor.sv
module seg_pkt_monitor
   import seg_pkt_pkg::*;
#(
   parameter int SEG_COUNT  = 4,
   parameter int SEG_BITS   = 256,
   parameter int MAX_STARTS = 3,
   parameter int READY_LAT  = 0,
   parameter int CNT_W      = 32,
   localparam int DATA_W    = SEG_COUNT * SEG_BITS,
   localparam int KEEP_W    = DATA_W / 8,
   localparam int SC_W      = $clog2(SEG_COUNT + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 rdy_en,
   output logic                 out_ready,
   input  logic                 in_valid,
   input  logic [KEEP_W-1:0]    in_keep,
   input  logic                 in_last,
   input  logic [SEG_COUNT-1:0] in_seg_end,
   input  logic [SEG_COUNT-1:0] in_seg_hdr,
   output logic [CNT_W-1:0]     pkt_done_cnt,
   output logic [SC_W-1:0]      beat_starts,
   output logic [ERR_W-1:0]     err_flags
);
   if (SEG_BITS % 8 != 0) begin : g_bad_seg
      $error("SEG_BITS must be a whole number of bytes");
   end
   if (SEG_COUNT < 1) begin : g_bad_count
      $error("SEG_COUNT must be at least 1");
   end
   if (MAX_STARTS < 1 || MAX_STARTS > SEG_COUNT) begin : g_bad_limit
      $error("MAX_STARTS must lie between 1 and SEG_COUNT");
   end
   if (READY_LAT < 0) begin : g_bad_lat
      $error("READY_LAT must not be negative");
   end
   if (CNT_W < SC_W) begin : g_bad_cnt
      $error("CNT_W too narrow");
   end

   logic            accept_ok;
   logic            xfer;
   logic            pkt_open;
   logic            open_next;
   logic [SC_W-1:0] n_starts;
   logic [SC_W-1:0] n_done;
   logic            hole_err, sparse_err, missing_err, orphan_err;
   err_vec_t        new_err;

   assign out_ready = rdy_en;

   // Ready-latency variants: same cycle, or a delay line of past ready values.
   if (READY_LAT == 0) begin : g_lat_zero
      assign accept_ok = rdy_en;
   end else begin : g_lat_line
      logic [READY_LAT-1:0] rdy_line;
      if (READY_LAT == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) rdy_line <= '0;
            else     rdy_line <= rdy_en;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (rst) rdy_line <= '0;
            else     rdy_line <= {rdy_line[READY_LAT-2:0], rdy_en};
         end
      end
      assign accept_ok = rdy_line[READY_LAT-1];
   end

   assign xfer = in_valid && accept_ok;

   spm_keep_check #(.KEEP_W(KEEP_W)) u_keep (
      .keep       (in_keep),
      .last       (in_last),
      .hole_err   (hole_err),
      .sparse_err (sparse_err)
   );

   spm_seg_scan #(.SEG_COUNT(SEG_COUNT)) u_scan (
      .open_in     (pkt_open),
      .seg_hdr     (in_seg_hdr),
      .seg_end     (in_seg_end),
      .open_out    (open_next),
      .n_starts    (n_starts),
      .n_done      (n_done),
      .missing_err (missing_err),
      .orphan_err  (orphan_err)
   );

   always_comb begin
      new_err                  = '0;
      new_err[E_KEEP_HOLE]     = hole_err;
      new_err[E_KEEP_SPARSE]   = sparse_err;
      new_err[E_START_LIMIT]   = (int'(n_starts) > MAX_STARTS);
      new_err[E_MISSING_END]   = missing_err;
      new_err[E_ORPHAN_END]    = orphan_err;
      new_err[E_LAST_MISMATCH] = (in_last == open_next);
   end

   spm_tally #(.CNT_W(CNT_W), .SC_W(SC_W)) u_tally (
      .clk          (clk),
      .rst          (rst),
      .xfer         (xfer),
      .open_next    (open_next),
      .n_starts     (n_starts),
      .n_done       (n_done),
      .new_err      (new_err),
      .pkt_open     (pkt_open),
      .pkt_done_cnt (pkt_done_cnt),
      .beat_starts  (beat_starts),
      .err_flags    (err_flags)
   );
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
   parameter int SEG_COUNT  = 4,
   parameter int KEEP_W     = 128,
   parameter int MAX_STARTS = 3,
   parameter int CNT_W      = 32,
   parameter int SC_W       = 3,
   parameter int ERR_W      = 6
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 xfer,
   input logic                 in_last,
   input logic [KEEP_W-1:0]    in_keep,
   input logic [SEG_COUNT-1:0] in_seg_hdr,
   input logic [CNT_W-1:0]     pkt_done_cnt,
   input logic [SC_W-1:0]      beat_starts,
   input logic [ERR_W-1:0]     err_flags
);
   a_r3_starts_follow: assert property (@(posedge clk) disable iff (rst)
      xfer |=> (int'(beat_starts) == $past($countones(in_seg_hdr))));

   a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !xfer |=> (beat_starts == '0));

   a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
      !xfer |=> $stable(pkt_done_cnt));

   a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
      xfer |=> (int'(pkt_done_cnt - $past(pkt_done_cnt)) <= SEG_COUNT));

   a_r5_keep_hole: assert property (@(posedge clk) disable iff (rst)
      (xfer && !in_last && !(&in_keep)) |=> err_flags[0]);

   a_r7_start_limit: assert property (@(posedge clk) disable iff (rst)
      (xfer && ($countones(in_seg_hdr) > MAX_STARTS)) |=> err_flags[2]);

   a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

   a_r1_errors_quiet: assert property (@(posedge clk) disable iff (rst)
      !xfer |=> $stable(err_flags));
endmodule

bind seg_pkt_monitor spm_checker #(
   .SEG_COUNT  (SEG_COUNT),
   .KEEP_W     (KEEP_W),
   .MAX_STARTS (MAX_STARTS),
   .CNT_W      (CNT_W),
   .SC_W       (SC_W),
   .ERR_W      (seg_pkt_pkg::ERR_W)
) u_spm_checker (
   .clk          (clk),
   .rst          (rst),
   .xfer         (xfer),
   .in_last      (in_last),
   .in_keep      (in_keep),
   .in_seg_hdr   (in_seg_hdr),
   .pkt_done_cnt (pkt_done_cnt),
   .beat_starts  (beat_starts),
   .err_flags    (err_flags)
);

// File: tb/seg_pkt_monitor_bench.sv
module seg_pkt_monitor_bench;
   localparam int CLK_PERIOD = 10;
   localparam int KW = 128;
   localparam logic [KW-1:0] FULL = '1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          rdy_en = 1'b0, in_valid = 1'b0, in_last = 1'b0;
   logic [KW-1:0] in_keep = '1;
   logic [3:0]    in_seg_end = '0, in_seg_hdr = '0;
   logic          out_ready;
   logic [31:0]   pkt_done_cnt;
   logic [2:0]    beat_starts;
   logic [5:0]    err_flags;

   logic          rdy2 = 1'b0, val2 = 1'b0, out_ready2;
   logic [31:0]   cnt2;
   logic [2:0]    starts2;
   logic [5:0]    err2;

   int n_chk = 0, n_err = 0;
   logic        exp_open = 1'b0;
   logic [31:0] exp_cnt = '0;
   logic [2:0]  exp_starts = '0;
   logic [5:0]  exp_err = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_pkt_monitor u_seg_pkt_monitor (
      .clk(clk), .rst(rst), .rdy_en(rdy_en), .out_ready(out_ready),
      .in_valid(in_valid), .in_keep(in_keep), .in_last(in_last),
      .in_seg_end(in_seg_end), .in_seg_hdr(in_seg_hdr),
      .pkt_done_cnt(pkt_done_cnt), .beat_starts(beat_starts), .err_flags(err_flags));

   seg_pkt_monitor #(.READY_LAT(2)) u_lat (
      .clk(clk), .rst(rst), .rdy_en(rdy2), .out_ready(out_ready2),
      .in_valid(val2), .in_keep(in_keep), .in_last(in_last),
      .in_seg_end(in_seg_end), .in_seg_hdr(in_seg_hdr),
      .pkt_done_cnt(cnt2), .beat_starts(starts2), .err_flags(err2));

   function automatic string errtag(int i);
      case (i)
         0: return "R5 keep hole";
         1: return "R6 sparse keep";
         2: return "R7 start limit";
         3: return "R8 missing end";
         4: return "R9 orphan end";
         default: return "R10 last mismatch";
      endcase
   endfunction

   function automatic logic pred_open(logic o, logic [3:0] h, logic [3:0] e);
      for (int i = 0; i < 4; i++) begin
         if (h[i]) o = 1'b1;
         if (e[i]) o = 1'b0;
      end
      return o;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_beat(logic [3:0] h, logic [3:0] e, logic [KW-1:0] k, logic l);
      logic s = exp_open;
      int st = 0, dn = 0;
      logic [5:0] ne = '0;
      for (int i = 0; i < 4; i++) begin
         if (h[i]) begin st++; if (s) ne[3] = 1'b1; s = 1'b1; end
         if (e[i]) begin
            if (s) begin dn++; s = 1'b0; end
            else ne[4] = 1'b1;
         end
      end
      if (!l && k != FULL) ne[0] = 1'b1;
      if ((k & (k + KW'(1))) != '0) ne[1] = 1'b1;
      if (st > 3) ne[2] = 1'b1;
      if (l != !s) ne[5] = 1'b1;
      exp_open = s;
      exp_cnt = exp_cnt + 32'(dn);
      exp_starts = 3'(st);
      exp_err = exp_err | ne;
   endtask

   task automatic check_all();
      chk("R2 ready follows enable", {31'b0, out_ready}, {31'b0, rdy_en});
      chk("R3 beat starts", {29'b0, beat_starts}, {29'b0, exp_starts});
      chk("R4 done count", pkt_done_cnt, exp_cnt);
      for (int i = 0; i < 6; i++)
         chk(errtag(i), {31'b0, err_flags[i]}, {31'b0, exp_err[i]});
   endtask

   task automatic beat(logic v, logic r, logic [3:0] h, logic [3:0] e,
                       logic [KW-1:0] k, logic l);
      in_valid = v; rdy_en = r; in_seg_hdr = h; in_seg_end = e;
      in_keep = k; in_last = l;
      if (v && r) model_beat(h, e, k, l);
      else exp_starts = '0;
      @(negedge clk);
      check_all();
   endtask

   task automatic do_reset();
      rst = 1'b1; in_valid = 1'b0; rdy_en = 1'b1; val2 = 1'b0; rdy2 = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      exp_open = 1'b0; exp_cnt = '0; exp_starts = '0; exp_err = '0;
      chk("R11 reset count", pkt_done_cnt, 32'd0);
      chk("R11 reset starts", {29'b0, beat_starts}, 32'd0);
      chk("R11 reset errors", {26'b0, err_flags}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] hold;
      @(negedge clk);
      do_reset();

      // R4: single-segment packet, two packets in a beat, three in a beat
      beat(1, 1, 4'b0001, 4'b0001, FULL, 1);
      beat(1, 1, 4'b0101, 4'b0110, FULL, 1);
      beat(1, 1, 4'b0111, 4'b0111, FULL, 1);
      // R4: packet spanning two beats, partial contiguous keep on last beat
      beat(1, 1, 4'b1000, 4'b0000, FULL, 0);
      beat(1, 1, 4'b0000, 4'b0001, FULL >> 88, 1);
      // R1: flags ignored without valid, and without ready
      hold = pkt_done_cnt;
      beat(0, 1, 4'b1111, 4'b1111, 128'h5, 0);
      beat(1, 0, 4'b1111, 4'b1111, 128'h5, 0);
      chk("R1 flags ignored", pkt_done_cnt, hold);
      chk("R1 no error from ignored beats", {26'b0, err_flags}, 32'd0);

      // error rules, one at a time
      beat(1, 1, 4'b0000, 4'b0001, FULL, 1);            // R9
      beat(1, 1, 4'b1111, 4'b1111, FULL, 1);            // R7
      beat(1, 1, 4'b0011, 4'b0010, FULL, 1);            // R8
      beat(1, 1, 4'b0001, 4'b0000, FULL, 1);            // R10 open with last
      beat(1, 1, 4'b0000, 4'b0001, FULL, 0);            // R10 closed without last
      beat(1, 1, 4'b0001, 4'b0001, FULL >> 8, 0);       // R5
      beat(1, 1, 4'b0001, 4'b0001, FULL ^ (KW'(1) << 5), 1); // R6
      beat(1, 1, 4'b0001, 4'b0001, FULL, 1);
      chk("R11 errors stay set", {26'b0, err_flags}, 32'h3f);
      do_reset();

      // R2: ready latency of two cycles on the second instance
      in_seg_hdr = 4'b0001; in_seg_end = 4'b0001; in_keep = FULL; in_last = 1'b1;
      in_valid = 1'b0;
      rdy2 = 1'b1; val2 = 1'b1; @(negedge clk);
      chk("R2 lat ready out", {31'b0, out_ready2}, 32'd1);
      chk("R2 lat no take at ready", cnt2, 32'd0);
      rdy2 = 1'b0; @(negedge clk);
      chk("R2 lat no take one later", cnt2, 32'd0);
      @(negedge clk);
      chk("R2 lat take two later", cnt2, 32'd1);
      @(negedge clk);
      chk("R2 lat single take", cnt2, 32'd1);
      val2 = 1'b0;
      do_reset();

      // constrained random phase
      void'($urandom(32'h5e6a11));
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] h, e;
         logic [KW-1:0] k;
         logic l;
         h = 4'($urandom);
         e = 4'($urandom);
         if ($urandom % 3 == 0) h = h & 4'b0101;
         l = pred_open(exp_open, h, e) ? 1'b0 : 1'b1;
         if ($urandom % 10 == 0) l = ~l;
         k = FULL;
         if (l && $urandom % 3 == 0) k = FULL >> ($urandom % KW);
         if ($urandom % 40 == 0) k = {4{$urandom}};
         beat($urandom % 5 != 0, $urandom % 4 != 0, h, e, k, l);
         if (n % 700 == 699) do_reset();
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule